// File: doc/BRIEF.md
# Monochrome Expansion Unpacker

This block expands a one-bit-per-pixel bitmap into 32-bit A8R8G8B8 pixels for a rectangle of programmable width and height. The bitmap arrives as 32-bit words on a valid/ready input. Every set bit becomes the foreground colour and every clear bit becomes the background colour. Each expanded pixel leaves on a valid/ready output together with its x and y position inside the rectangle, at a rate of up to one pixel per clock.

A packing mode controls how the bits of a word map onto the rectangle. In the three tiled modes, one word covers a small tile that is 8, 16 or 32 pixels wide and 4, 2 or 1 rows tall. Tiles run left to right across a band of rows, then continue with the band below. In linear mode the bits form one continuous stream along the rows, and a row may end in the middle of a word.

A mask mode reuses the same walk for masked blits. In that mode the colour output is zero and only the per-pixel bit matters, because the colour data is fetched elsewhere. A run begins with a start pulse, which latches the geometry and the modes. It ends with a one-cycle done pulse.

Top module: `mxu_unpacker`

## Requirements
- R1: After reset, out_valid, in_ready and done are all low.
- R2: A start pulse with rect_w or rect_h equal to zero is ignored: no run begins and in_ready stays low.
- R3: Tiled packing codes are 1 = 8x4, 2 = 16x2 and 3 = 32x1 (width x rows per word). Bit i of a word sits at column i mod width and row i / width inside its tile. Tiles advance left to right, and a new band of rows starts with the next word once the band is full.
- R4: Packing code 0 is linear. Pixel k of the rectangle in row-major order is bit k mod 32 of word k / 32, so rows continue inside a word.
- R5: Pixels at or beyond rect_w or rect_h are never emitted. Every emitted position lies inside the rectangle.
- R6: With mask_mode low, a bit of 1 gives out_color = fg_color and a bit of 0 gives out_color = bg_color. out_bit carries the bit.
- R7: With mask_mode high, out_color is zero and out_bit carries the bitmap bit.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_x, out_y, out_bit and out_color hold their values.
- R9: in_ready is high only during a run when no word is held. It never rises in the same cycle as out_valid. After the last pixel, any remaining bits of the final word are discarded and in_ready stays low.
- R10: done is high for exactly one cycle, in the cycle after the handshake of the pixel at (rect_w-1, rect_h-1). The block is then idle.
- R11: A start pulse during a run is ignored. The latched geometry and modes apply until that run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; geometry and modes are latched |
| pack_mode | input | 2 | Packing code (0 linear, 1/2/3 tiled) |
| mask_mode | input | 1 | Emit mask bits only; colour output forced to zero |
| rect_w | input | COORD_W | Rectangle width in pixels |
| rect_h | input | COORD_W | Rectangle height in pixels |
| fg_color | input | 32 | A8R8G8B8 colour for set bits |
| bg_color | input | 32 | A8R8G8B8 colour for clear bits |
| in_valid | input | 1 | Bitmap word valid |
| in_ready | output | 1 | Bitmap word accepted |
| in_data | input | 32 | Bitmap word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel accepted downstream |
| out_color | output | 32 | Expanded A8R8G8B8 pixel |
| out_bit | output | 1 | Bitmap bit of this pixel |
| out_x | output | COORD_W | Pixel column |
| out_y | output | COORD_W | Pixel row |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
A wrong bit index or tile origin in the walker appears at the ports on the very next handshake, as a wrong out_x, out_y or out_bit. The bench compares every pixel in order against its own tile-order model, so such an error is caught at the first affected pixel. A wrong band or row wrap shows one handshake later, at the first pixel of the next word or row. A stuck held-word flag shows as either a hang or an early in_ready. The first is caught by the final pixel count and done check; the second shows one cycle after the word is taken.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

  typedef enum logic [1:0] {
    PK_LINEAR = 2'd0,
    PK_W8     = 2'd1,
    PK_W16    = 2'd2,
    PK_W32    = 2'd3
  } pack_e;

  // log2 of the tile width for a tiled packing code
  function automatic logic [2:0] tile_w_log2(input pack_e m);
    case (m)
      PK_W8:   return 3'd3;
      PK_W16:  return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // colour chosen for one bitmap bit
  function automatic logic [31:0] expand_bit(input logic b, input logic mask,
                                             input logic [31:0] fg,
                                             input logic [31:0] bg);
    if (mask) return 32'h0;
    return b ? fg : bg;
  endfunction

endpackage

// File: rtl/mxu_word_hold.sv
module mxu_word_hold (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        consume,
  output logic        in_ready,
  output logic [31:0] word,
  output logic        word_vld
);

  logic take;

  assign in_ready = busy && !word_vld;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else if (take) begin
      word     <= in_data;
      word_vld <= 1'b1;
    end else if (consume) begin
      word_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/mxu_walker.sv
module mxu_walker
  import mxu_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  pack_e              mode,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  output logic [4:0]         bit_idx,
  output logic [COORD_W:0]   pos_x,
  output logic [COORD_W:0]   pos_y,
  output logic               in_range,
  output logic               last_pix
);

  localparam int XW = COORD_W + 1;

  logic [XW-1:0] tile_x, band_y, lin_x, lin_y;
  logic [XW-1:0] w_ext, h_ext, tile_x_nxt;
  logic [2:0]    lg;
  logic [5:0]    tw, th;
  logic [4:0]    col, row;
  logic          linear;

  always_comb begin
    linear     = (mode == PK_LINEAR);
    lg         = tile_w_log2(mode);
    tw         = 6'd1 << lg;
    th         = 6'd32 >> lg;
    col        = bit_idx & (tw[4:0] - 5'd1);
    row        = bit_idx >> lg;
    w_ext      = {1'b0, rect_w};
    h_ext      = {1'b0, rect_h};
    pos_x      = linear ? lin_x : tile_x + XW'(col);
    pos_y      = linear ? lin_y : band_y + XW'(row);
    in_range   = (pos_x < w_ext) && (pos_y < h_ext);
    last_pix   = (pos_x == w_ext - 1'b1) && (pos_y == h_ext - 1'b1);
    tile_x_nxt = tile_x + XW'(tw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      bit_idx <= '0;
      tile_x  <= '0;
      band_y  <= '0;
      lin_x   <= '0;
      lin_y   <= '0;
    end else if (step) begin
      bit_idx <= bit_idx + 5'd1;
      if (linear) begin
        if (lin_x == w_ext - 1'b1) begin
          lin_x <= '0;
          lin_y <= lin_y + 1'b1;
        end else begin
          lin_x <= lin_x + 1'b1;
        end
      end else if (bit_idx == 5'd31) begin
        if (tile_x_nxt >= w_ext) begin
          tile_x <= '0;
          band_y <= band_y + XW'(th);
        end else begin
          tile_x <= tile_x_nxt;
        end
      end
    end
  end

  // R4: in linear mode every walked position is inside the rectangle
  a_r4_linear_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
    linear && step |-> in_range);

endmodule

// File: rtl/mxu_unpacker.sv
module mxu_unpacker
  import mxu_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         pack_mode,
  input  logic               mask_mode,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [31:0]        fg_color,
  input  logic [31:0]        bg_color,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_color,
  output logic               out_bit,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic               done
);

  logic               busy, mask_q, done_q;
  pack_e              mode_q;
  logic [COORD_W-1:0] w_q, h_q;

  logic        start_ok, step, fire, finish, consume;
  logic [31:0] word;
  logic        word_vld;
  logic [4:0]  bit_idx;
  logic [COORD_W:0] pos_x, pos_y;
  logic        in_range, last_pix;

  assign start_ok = start && !busy && (rect_w != '0) && (rect_h != '0);

  mxu_word_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .in_valid (in_valid),
    .in_data  (in_data),
    .consume  (consume),
    .in_ready (in_ready),
    .word     (word),
    .word_vld (word_vld)
  );

  mxu_walker #(.COORD_W(COORD_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .step     (step),
    .mode     (mode_q),
    .rect_w   (w_q),
    .rect_h   (h_q),
    .bit_idx  (bit_idx),
    .pos_x    (pos_x),
    .pos_y    (pos_y),
    .in_range (in_range),
    .last_pix (last_pix)
  );

  // named internal events
  assign out_valid = busy && word_vld && in_range;
  assign step      = busy && word_vld && (!in_range || out_ready);
  assign fire      = out_valid && out_ready;
  assign finish    = fire && last_pix;
  assign consume   = step && ((bit_idx == 5'd31) || finish);

  assign out_bit   = word[bit_idx];
  assign out_color = expand_bit(out_bit, mask_q, fg_color, bg_color);
  assign out_x     = pos_x[COORD_W-1:0];
  assign out_y     = pos_y[COORD_W-1:0];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mask_q <= 1'b0;
      mode_q <= PK_LINEAR;
      w_q    <= '0;
      h_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_ok) begin
        busy   <= 1'b1;
        mask_q <= mask_mode;
        mode_q <= pack_e'(pack_mode);
        w_q    <= rect_w;
        h_q    <= rect_h;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  // R5: emitted positions stay inside the latched rectangle
  a_r5_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x < w_q) && (out_y < h_q));

  // R8: a stalled pixel holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
                                && $stable(out_bit) && $stable(out_color));

  // R9: word intake and pixel output never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R10: done is a single-cycle pulse after which the block is idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R2, R11: a run only begins from a start pulse
  a_r2_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/mxu_unpacker_tb_top.sv
`timescale 1ns/1ps
module mxu_unpacker_tb_top;

  localparam int CW = 12;
  localparam logic [31:0] FG = 32'hFF12_3456;
  localparam logic [31:0] BG = 32'h80AB_CDEF;

  // {mode[35:34], mask[33], stall[32], w[31:24], h[23:16], seed[15:0]}
  localparam logic [35:0] VEC [10] = '{
    {2'd1, 1'b0, 1'b0, 8'd8,  8'd4, 16'h1A2B},
    {2'd1, 1'b0, 1'b1, 8'd13, 8'd6, 16'h0F0F},
    {2'd2, 1'b0, 1'b0, 8'd20, 8'd3, 16'h7777},
    {2'd3, 1'b0, 1'b1, 8'd40, 8'd2, 16'h1234},
    {2'd0, 1'b0, 1'b0, 8'd7,  8'd5, 16'hBEEF},
    {2'd0, 1'b1, 1'b1, 8'd33, 8'd3, 16'h4242},
    {2'd1, 1'b1, 1'b0, 8'd1,  8'd1, 16'h0003},
    {2'd3, 1'b0, 1'b0, 8'd5,  8'd1, 16'h5A5A},
    {2'd2, 1'b1, 1'b1, 8'd17, 8'd5, 16'hC0DE},
    {2'd1, 1'b0, 1'b1, 8'd40, 8'd9, 16'h9999}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    pack_mode;
  logic          mask_mode;
  logic [CW-1:0] rect_w, rect_h;
  logic          in_valid, in_ready;
  logic [31:0]   in_data;
  logic          out_valid, out_ready;
  logic [31:0]   out_color;
  logic          out_bit;
  logic [CW-1:0] out_x, out_y;
  logic          done;

  always #2 clk = ~clk;

  mxu_unpacker #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pack_mode(pack_mode),
    .mask_mode(mask_mode), .rect_w(rect_w), .rect_h(rect_h),
    .fg_color(FG), .bg_color(BG), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_color(out_color), .out_bit(out_bit), .out_x(out_x), .out_y(out_y),
    .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          ex_x [2048];
  int          ex_y [2048];
  logic        ex_b [2048];
  logic [31:0] wds  [64];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int mode, input bit mask, input bit stall,
                          input int w, input int h, input logic [15:0] seed,
                          input bit restart);
    int n = 0;
    int nw;
    int got = 0;
    int guard = 0;
    bit held = 0;
    logic [31:0] s_col;
    int s_x, s_y;
    string ptag = (mode == 0) ? "R4" : "R3";
    string ctag = mask ? "R7" : "R6";
    for (int i = 0; i < 64; i++)
      wds[i] = ({16'h0, seed} * 32'h9E37_79B1) ^ (i * 32'h85EB_CA77) ^ (i << 7);
    if (mode == 0) begin
      nw = (w * h + 31) / 32;
      for (int k = 0; k < w * h; k++) begin
        ex_x[n] = k % w; ex_y[n] = k / w; ex_b[n] = wds[k / 32][k % 32]; n++;
      end
    end else begin
      int tw = (mode == 1) ? 8 : (mode == 2) ? 16 : 32;
      int th = 32 / tw;
      int ntx = (w + tw - 1) / tw;
      int nby = (h + th - 1) / th;
      nw = ntx * nby;
      for (int b = 0; b < nby; b++)
        for (int t = 0; t < ntx; t++)
          for (int i = 0; i < 32; i++) begin
            int x = t * tw + i % tw;
            int y = b * th + i / tw;
            if (x < w && y < h) begin
              ex_x[n] = x; ex_y[n] = y; ex_b[n] = wds[b * ntx + t][i]; n++;
            end
          end
    end
    @(negedge clk);
    pack_mode = mode[1:0]; mask_mode = mask;
    rect_w = CW'(w); rect_h = CW'(h); start = 1'b1;
    @(negedge clk);
    if (restart) begin
      pack_mode = 2'd1; mask_mode = ~mask; rect_w = CW'(w + 5); rect_h = CW'(h + 3);
      @(negedge clk);
    end
    start = 1'b0;
    fork
      begin : feed
        for (int i = 0; i < nw; i++) begin
          if (stall && (i % 4 == 3)) begin in_valid = 1'b0; @(negedge clk); end
          in_valid = 1'b1; in_data = wds[i];
          while (!in_ready) @(negedge clk);
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin : drain
        while (got < n && guard < 20000) begin
          if (guard != 0 || got != 0) @(negedge clk);
          guard++;
          out_ready = stall ? (cyc % 3 != 0) : 1'b1;
          if (held)
            chk(out_valid && out_color == s_col && int'(out_x) == s_x && int'(out_y) == s_y,
                "R8", "stalled pixel changed", {out_x, out_y}, {CW'(s_x), CW'(s_y)});
          held = 0;
          if (done) chk(0, "R10", "early done", 1, 0);
          if (out_valid) begin
            if (out_ready) begin
              chk(int'(out_x) == ex_x[got] && int'(out_y) == ex_y[got] && out_bit == ex_b[got],
                  ptag, "pixel position/bit", {out_x, out_y, out_bit},
                  {CW'(ex_x[got]), CW'(ex_y[got]), ex_b[got]});
              chk(out_color == (mask ? 32'h0 : (ex_b[got] ? FG : BG)), ctag, "colour",
                  out_color, mask ? 32'h0 : (ex_b[got] ? FG : BG));
              chk(int'(out_x) < w && int'(out_y) < h, "R5", "outside rectangle",
                  {out_x, out_y}, {CW'(w), CW'(h)});
              got++;
            end else begin
              held = 1; s_col = out_color; s_x = int'(out_x); s_y = int'(out_y);
            end
          end
        end
        @(negedge clk);
        chk(done == 1'b1, "R10", "done after last pixel", done, 1);
        chk(in_ready == 1'b0, "R9", "in_ready after finish", in_ready, 0);
        chk(out_valid == 1'b0, "R9", "leftover bits emitted", out_valid, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done longer than one cycle", done, 0);
        out_ready = 1'b0;
        if (restart) chk(got == n, "R11", "pixel count after restart attempt", got, n);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pack_mode = 2'd0; mask_mode = 1'b0;
    rect_w = '0; rect_h = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    // R2: zero width, then zero height
    rect_w = '0; rect_h = CW'(4); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", "run began with zero width", in_ready, 0);
    rect_w = CW'(4); rect_h = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", "run began with zero height", in_ready, 0);

    for (int v = 0; v < 10; v++)
      run_case(int'(VEC[v][35:34]), VEC[v][33], VEC[v][32], int'(VEC[v][31:24]),
               int'(VEC[v][23:16]), VEC[v][15:0], 1'b0);

    // R11: second start during a run, with different geometry and modes
    run_case(0, 1'b0, 1'b0, 4, 1, 16'h0055, 1'b1);
    run_case(2, 1'b0, 1'b1, 9, 3, 16'h0AA0, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule